// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control sequencer of a small accumulator-style processor. It waits in a decode state until a start request comes in while the destination gate bit is clear. It then latches the 3-bit instruction code into one of eight execute states. Each execute state drives a fixed operation code to the datapath. The datapath itself sits outside this block.

Most instructions execute in a single cycle. Subtraction takes two. The sequencer first spends one cycle issuing a two's-complement negate code, and then passes through the shared add state. Once the last execute cycle ends, the sequencer returns to decode and raises `done` for one cycle. Inputs are sampled only in decode, so the surrounding logic may change `start`, `instr` and `dest` freely while an instruction runs.

Top module: `instr_sequencer`

## Requirements
- R1: While in decode, the sequencer stays in decode when `start` is 0 or `dest[1]` is 1 at the clock edge. `dp_op` stays 0 (idle code) in that case.
- R2: When `start` is 1 and `dest[1]` is 0 at a clock edge in decode, the next cycle shows a non-idle execute opcode on `dp_op`.
- R3: The first execute opcode depends on `instr`:
  - 0: load, code 1
  - 1: transfer, code 2
  - 2: AND, code 3
  - 3: OR, code 4
  - 4: add, code 5
  - 5: subtract, negate code 6
  - 6: shift right logical, code 7
  - 7: output, code 8
- R4: The subtract sequence issues the negate code 6 for exactly one cycle. The add code 5 follows in the next cycle unconditionally.
- R5: The cycle after the final execute cycle shows `dp_op` = 0 and `done` = 1. This is one execute cycle for every instruction except subtract, which takes two.
- R6: `done` is 0 in the cycle after any cycle spent in decode.
- R7: Driving `rst_n` low forces `dp_op` to 0 and `done` to 0 at once, without waiting for a clock. After `rst_n` rises, the first two clock edges are still treated as reset, and a start is accepted only from the third edge on.
- R8: `start`, `instr` and `dest` have no effect while an execute state is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| start | input | 1 | Request to begin an instruction, sampled in decode only |
| instr | input | 3 | Instruction code |
| dest | input | 2 | Destination field; bit 1 set blocks a start |
| dp_op | output | 4 | Operation code to the datapath |
| done | output | 1 | One-cycle flag after an instruction completes |

## Verification
The current state shows directly on `dp_op` in the same cycle, so a wrong state transition appears on the ports one cycle after the offending edge. A wrong branch shows as the wrong execute code. A skipped negate cycle shows as code 5 appearing right after decode, with `done` arriving a cycle early. A missed return to decode shows as `done` staying low and `dp_op` staying non-zero beyond the expected cycle. Re-acceptance of `start` during execution would change the opcode sequence within one cycle.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

  localparam int unsigned INSTR_W = 3;
  localparam int unsigned OP_W    = 4;

  typedef enum logic [3:0] {
    ST_DECODE = 4'd0,
    ST_LOAD   = 4'd1,
    ST_XFER   = 4'd2,
    ST_AND    = 4'd3,
    ST_OR     = 4'd4,
    ST_ADD    = 4'd5,
    ST_SUB    = 4'd6,
    ST_SHR    = 4'd7,
    ST_OUT    = 4'd8
  } seq_state_t;

  localparam logic [OP_W-1:0] OP_IDLE = 4'd0;
  localparam logic [OP_W-1:0] OP_LOAD = 4'd1;
  localparam logic [OP_W-1:0] OP_XFER = 4'd2;
  localparam logic [OP_W-1:0] OP_AND  = 4'd3;
  localparam logic [OP_W-1:0] OP_OR   = 4'd4;
  localparam logic [OP_W-1:0] OP_ADD  = 4'd5;
  localparam logic [OP_W-1:0] OP_NEG  = 4'd6;
  localparam logic [OP_W-1:0] OP_SHR  = 4'd7;
  localparam logic [OP_W-1:0] OP_OUT  = 4'd8;

endpackage

// File: rtl/iseq_rst_sync.sv
module iseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] chain_q;

  // Assertion is immediate; release walks through the chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[NS-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[NS-1];

endmodule

// File: rtl/iseq_next.sv
module iseq_next
  import iseq_pkg::*;
(
  input  seq_state_t         state_q,
  input  logic               start,
  input  logic               gate_blk,
  input  logic [INSTR_W-1:0] instr,
  output seq_state_t         state_nxt,
  output logic               done_nxt
);

  always_comb begin
    state_nxt = state_q;
    done_nxt  = 1'b0;
    unique case (state_q)
      ST_DECODE: begin
        done_nxt = 1'b0;
        if (start && !gate_blk) begin
          unique case (instr)
            3'd0: state_nxt = ST_LOAD;
            3'd1: state_nxt = ST_XFER;
            3'd2: state_nxt = ST_AND;
            3'd3: state_nxt = ST_OR;
            3'd4: state_nxt = ST_ADD;
            3'd5: state_nxt = ST_SUB;
            3'd6: state_nxt = ST_SHR;
            default: state_nxt = ST_OUT;
          endcase
        end
      end
      ST_SUB: begin
        // Negate cycle, then fall into the shared add state.
        state_nxt = ST_ADD;
        done_nxt  = 1'b0;
      end
      ST_LOAD, ST_XFER, ST_AND, ST_OR, ST_ADD, ST_SHR, ST_OUT: begin
        state_nxt = ST_DECODE;
        done_nxt  = 1'b1;
      end
      default: begin
        state_nxt = ST_DECODE;
        done_nxt  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/iseq_opdec.sv
module iseq_opdec
  import iseq_pkg::*;
(
  input  seq_state_t        state_q,
  output logic [OP_W-1:0]   dp_op
);

  always_comb begin
    unique case (state_q)
      ST_LOAD: dp_op = OP_LOAD;
      ST_XFER: dp_op = OP_XFER;
      ST_AND:  dp_op = OP_AND;
      ST_OR:   dp_op = OP_OR;
      ST_ADD:  dp_op = OP_ADD;
      ST_SUB:  dp_op = OP_NEG;
      ST_SHR:  dp_op = OP_SHR;
      ST_OUT:  dp_op = OP_OUT;
      default: dp_op = OP_IDLE;
    endcase
  end

endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import iseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEST_W      = 2,
  parameter int unsigned GATE_BIT    = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [DEST_W-1:0]   dest,
  output logic [OP_W-1:0]     dp_op,
  output logic                done
);

  logic       rst_sync_n;
  seq_state_t state_q;
  seq_state_t state_nxt;
  logic       done_q;
  logic       done_nxt;
  logic       done_en;

  iseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  iseq_next u_next (
    .state_q   (state_q),
    .start     (start),
    .gate_blk  (dest[GATE_BIT]),
    .instr     (instr),
    .state_nxt (state_nxt),
    .done_nxt  (done_nxt)
  );

  // Flag register only toggles when its next value differs.
  assign done_en = (done_nxt != done_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_DECODE;
    end else begin
      state_q <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
    end else if (done_en) begin
      done_q <= done_nxt;
    end
  end

  iseq_opdec u_dec (
    .state_q (state_q),
    .dp_op   (dp_op)
  );

  assign done = done_q;

endmodule

// File: rtl/iseq_checker.sv
module iseq_checker
  import iseq_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic            start,
  input logic            gate_blk,
  input logic [OP_W-1:0] dp_op,
  input logic            done
);

  // R1
  a_r1_hold_decode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dp_op == OP_IDLE && !(start && !gate_blk)) |=> (dp_op == OP_IDLE));

  // R2
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dp_op == OP_IDLE && start && !gate_blk) |=> (dp_op != OP_IDLE));

  // R4
  a_r4_neg_then_add: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dp_op == OP_NEG) |=> (dp_op == OP_ADD));

  // R5
  a_r5_done_after_exec: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dp_op != OP_IDLE && dp_op != OP_NEG) |=> (done && dp_op == OP_IDLE));

  // R6
  a_r6_done_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dp_op == OP_IDLE) |=> !done);

  // R5: done never overlaps an execute cycle
  a_r5_done_only_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (dp_op == OP_IDLE));

endmodule

bind instr_sequencer iseq_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start      (start),
  .gate_blk   (dest[GATE_BIT]),
  .dp_op      (dp_op),
  .done       (done)
);

// File: tb/instr_sequencer_test.sv
module instr_sequencer_test;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [2:0] instr;
  logic [1:0] dest;
  logic [3:0] dp_op;
  logic       done;

  int checks;
  int failures;
  int cycles;

  instr_sequencer uut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .instr (instr),
    .dest  (dest),
    .dp_op (dp_op),
    .done  (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] first_op(input logic [2:0] code);
    case (code)
      3'd0: return 4'd1;
      3'd1: return 4'd2;
      3'd2: return 4'd3;
      3'd3: return 4'd4;
      3'd4: return 4'd5;
      3'd5: return 4'd6;
      3'd6: return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] exp_op, input logic exp_done);
    checks++;
    if (dp_op !== exp_op || done !== exp_done) begin
      failures++;
      $display("FAIL %s: dp_op=%0d done=%0b expected dp_op=%0d done=%0b",
               req, dp_op, done, exp_op, exp_done);
    end
  endtask

  task automatic scramble();
    start = 1'($urandom);
    instr = 3'($urandom);
    dest  = 2'($urandom);
  endtask

  // One instruction attempt starting from decode with done low.
  task automatic run_one(input logic [2:0] code, input logic [1:0] d, input logic s);
    logic acc;
    acc = s && !d[1];
    @(negedge clk);
    start = s; instr = code; dest = d;
    @(negedge clk);
    if (!acc) begin
      check("R1", 4'd0, 1'b0);
      start = 1'b0;
      return;
    end
    if (code == 3'd5) check("R4", 4'd6, 1'b0);
    else              check("R3", first_op(code), 1'b0);
    scramble(); // R8: inputs during execution must not matter
    if (code == 3'd5) begin
      @(negedge clk);
      check("R4", 4'd5, 1'b0);
      scramble();
    end
    @(negedge clk);
    check("R5", 4'd0, 1'b1);
    start = 1'b0;
    @(negedge clk);
    check("R6", 4'd0, 1'b0);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    checks = 0;
    failures = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; instr = '0; dest = '0;
    #5;
    check("R7", 4'd0, 1'b0);
    repeat (3) @(negedge clk);
    check("R7", 4'd0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed: every code once, accepted
    for (int i = 0; i < 8; i++) run_one(3'(i), 2'b00, 1'b1);
    // Directed: gate bit set blocks, gate clear with dest[0] set accepts
    run_one(3'd5, 2'b10, 1'b1);
    run_one(3'd5, 2'b11, 1'b1);
    run_one(3'd2, 2'b01, 1'b1);
    run_one(3'd7, 2'b00, 1'b0);

    // R7: asynchronous reset mid-subtract, then synchronized release
    @(negedge clk);
    start = 1'b1; instr = 3'd5; dest = 2'b00;
    @(negedge clk);
    check("R4", 4'd6, 1'b0);
    #3 rst_n = 1'b0;
    #1 check("R7", 4'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; start = 1'b1; instr = 3'd6; dest = 2'b00;
    @(negedge clk);
    check("R7", 4'd0, 1'b0);
    @(negedge clk);
    check("R7", 4'd0, 1'b0);
    @(negedge clk);
    check("R7", 4'd7, 1'b0);
    start = 1'b0;
    @(negedge clk);
    check("R5", 4'd0, 1'b1);
    @(negedge clk);
    check("R6", 4'd0, 1'b0);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      run_one(3'($urandom), 2'($urandom), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule